// File: doc/BRIEF.md
# Interrupt Level Priority Resolver

This block decides which maskable interrupt level, if any, should be raised to a processor core. It combines a 16-bit vector of external level requests with a software-interrupt register held inside the block. It then compares the result against the core's current interrupt level and picks the highest pending level strictly above it. The outcome is a hard-interrupt request flag and the trap type for that level. The trap type is the external-interrupt base value 0x40 ORed with the level number.

The software-interrupt register can be OR-set, AND-NOT cleared or overwritten through a small operation port. Its two timer-match bits are not levels in their own right. Either one of them raises level 14 instead. The block re-evaluates on every clock and holds its result in registers. Three conditions change the outcome. A pending vectored interrupt freezes the result. Disabled interrupts clear it. A nested trap already servicing a higher external level suppresses any new request. All ports are plain control and status signals. There is no stream data path, so no valid/ready handshake and no back-pressure applies.

Top module: `irq_level_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, `hard_req`, `irq_tt` and `softint_q` become zero at that edge.
- R2: `sw_op` encodes 0 = no change, 1 = OR `sw_data` into the register, 2 = clear the bits set in `sw_data`, 3 = load `sw_data`. `softint_q` shows the result one clock later.
- R3: The pending vector is `ext_req` ORed with `softint_q[15:0]`, with `softint_q[0]` masked off. If `softint_q[0]` or `softint_q[16]` is set, level 14 is also pending.
- R4: If the pending vector, read as an unsigned number, is below 2 << `proc_lvl`, the next edge clears `hard_req` and `irq_tt`. This holds whatever the value of `int_en`.
- R5: With `int_en` high and the pending vector at or above the threshold, the highest set level L with L > `proc_lvl` wins. The next edge sets `irq_tt` = 0x40 | L and `hard_req` = 1, unless `irq_tt` already equals that value, in which case both hold.
- R6: If `trap_lvl` is nonzero, `saved_tt[8:4]` equals 4 and `saved_tt` is greater than 0x40 | L, no new request is made. `hard_req` and `irq_tt` keep their values.
- R7: With `int_en` low and the pending vector at or above the threshold, the next edge clears `hard_req` and `irq_tt`.
- R8: While `vec_pend` is high, `hard_req` and `irq_tt` keep their values. The software-interrupt register still updates.
- R9: Changes on the level inputs reach `hard_req`/`irq_tt` one edge after they are applied. A software-interrupt operation reaches them two edges after it is applied, because evaluation uses the registered `softint_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_req | input | 16 | External level requests, bit n = level n |
| proc_lvl | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Interrupts enabled |
| vec_pend | input | 1 | Vectored interrupt pending, freezes evaluation |
| trap_lvl | input | 3 | Current trap nesting level |
| saved_tt | input | 9 | Trap type saved at the current trap level |
| sw_op | input | 2 | Software-interrupt register operation |
| sw_data | input | 17 | Operand for the software-interrupt operation |
| softint_q | output | 17 | Software-interrupt register value |
| hard_req | output | 1 | Hard interrupt request to the core |
| irq_tt | output | 9 | Selected trap type, zero when no request |

## Verification
The resolver's outputs update one edge after a level, enable, nesting or vectored-pending input is applied. They update two edges after a software-interrupt operation: one edge to write the register and one to evaluate the new value. The bench drives each new input set just after a falling edge. It advances a behavioural model by exactly one rising edge and compares every output at the next falling edge, so each result is checked in the cycle it becomes due. A dedicated sequence also checks that a software write has not yet raised the request after one edge and has raised it after two.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int NUM_LVL   = 16;
  localparam int LVL_W     = $clog2(NUM_LVL);
  localparam int SW_W      = 17;
  localparam int TT_W      = 9;
  localparam int TL_W      = 3;
  localparam int TICK_BIT  = 0;
  localparam int STICK_BIT = 16;
  localparam int TIMER_LVL = 14;
  localparam logic [TT_W-1:0] EXT_BASE = 9'h040;

  typedef enum logic [1:0] {
    SW_NOP = 2'd0,
    SW_SET = 2'd1,
    SW_CLR = 2'd2,
    SW_WR  = 2'd3
  } sw_op_e;
endpackage

// File: rtl/irqr_softint_reg.sv
module irqr_softint_reg
  import irqr_pkg::*;
#(
  parameter int W = SW_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    unique case (sw_op_e'(op))
      SW_SET:  nxt = q | data;
      SW_CLR:  nxt = q & ~data;
      SW_WR:   nxt = data;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/irqr_pend_merge.sv
module irqr_pend_merge
  import irqr_pkg::*;
#(
  parameter int N      = NUM_LVL,
  parameter int W      = SW_W,
  parameter int T_BIT  = TICK_BIT,
  parameter int S_BIT  = STICK_BIT,
  parameter int T_LVL  = TIMER_LVL
) (
  input  logic [N-1:0] ext,
  input  logic [W-1:0] sw,
  output logic [N-1:0] pend
);
  logic timer_hit;
  assign timer_hit = sw[T_BIT] | sw[S_BIT];

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic sw_part;
    if (g == T_BIT || g == S_BIT) begin : g_masked
      assign sw_part = 1'b0;
    end else begin : g_pass
      assign sw_part = sw[g];
    end
    if (g == T_LVL) begin : g_timer
      assign pend[g] = ext[g] | sw_part | timer_hit;
    end else begin : g_plain
      assign pend[g] = ext[g] | sw_part;
    end
  end
endmodule

// File: rtl/irqr_level_pick.sv
module irqr_level_pick
  import irqr_pkg::*;
#(
  parameter int N  = NUM_LVL,
  parameter int LW = LVL_W
) (
  input  logic [N-1:0]  pend,
  input  logic [LW-1:0] floor_lvl,
  output logic          above,
  output logic          found,
  output logic [LW-1:0] lvl
);
  localparam int CMP_W = N + 1;
  logic [CMP_W-1:0] thr;

  assign thr   = CMP_W'(2) << floor_lvl;
  assign above = {1'b0, pend} >= thr;

  always_comb begin
    found = 1'b0;
    lvl   = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (i > int'(floor_lvl))) begin
        found = 1'b1;
        lvl   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irqr_pkg::*;
#(
  parameter int N  = NUM_LVL,
  parameter int LW = LVL_W,
  parameter int SW = SW_W,
  parameter int TW = TT_W,
  parameter int TL = TL_W,
  parameter logic [TT_W-1:0] BASE = EXT_BASE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  ext_req,
  input  logic [LW-1:0] proc_lvl,
  input  logic          int_en,
  input  logic          vec_pend,
  input  logic [TL-1:0] trap_lvl,
  input  logic [TW-1:0] saved_tt,
  input  logic [1:0]    sw_op,
  input  logic [SW-1:0] sw_data,
  output logic [SW-1:0] softint_q,
  output logic          hard_req,
  output logic [TW-1:0] irq_tt
);
  logic [N-1:0]  pend;
  logic          above, found;
  logic [LW-1:0] win_lvl;
  logic [TW-1:0] cand_tt;
  logic          nest_block;
  logic          req_d;
  logic [TW-1:0] tt_d;

  irqr_softint_reg #(.W(SW)) u_sw (
    .clk(clk), .rst(rst), .op(sw_op), .data(sw_data), .q(softint_q)
  );

  irqr_pend_merge #(.N(N), .W(SW)) u_merge (
    .ext(ext_req), .sw(softint_q), .pend(pend)
  );

  irqr_level_pick #(.N(N), .LW(LW)) u_pick (
    .pend(pend), .floor_lvl(proc_lvl), .above(above), .found(found), .lvl(win_lvl)
  );

  assign cand_tt    = BASE | {{(TW-LW){1'b0}}, win_lvl};
  assign nest_block = (trap_lvl != '0)
                   && (saved_tt[TW-1:4] == BASE[TW-1:4])
                   && (saved_tt > cand_tt);

  always_comb begin
    req_d = hard_req;
    tt_d  = irq_tt;
    if (!vec_pend) begin
      if (!above || !int_en) begin
        req_d = 1'b0;
        tt_d  = '0;
      end else if (found && !nest_block && (irq_tt != cand_tt)) begin
        req_d = 1'b1;
        tt_d  = cand_tt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hard_req <= 1'b0;
      irq_tt   <= '0;
    end else begin
      hard_req <= req_d;
      irq_tt   <= tt_d;
    end
  end
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  proc_lvl,
  input logic        int_en,
  input logic        vec_pend,
  input logic [1:0]  sw_op,
  input logic [16:0] sw_data,
  input logic [16:0] softint_q,
  input logic        hard_req,
  input logic [8:0]  irq_tt
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!hard_req && irq_tt == 9'd0 && softint_q == 17'd0));

  assert_sw_set_R2: assert property (@(posedge clk) disable iff (rst)
    sw_op == 2'd1 |=> softint_q == ($past(softint_q) | $past(sw_data)));

  assert_sw_clear_R2: assert property (@(posedge clk) disable iff (rst)
    sw_op == 2'd2 |=> softint_q == ($past(softint_q) & ~$past(sw_data)));

  assert_req_above_lvl_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(hard_req) |-> irq_tt[3:0] > $past(proc_lvl));

  assert_tt_base_R5: assert property (@(posedge clk) disable iff (rst)
    hard_req |-> irq_tt[8:4] == 5'h04);

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !hard_req |-> irq_tt == 9'd0);

  assert_disabled_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!int_en && !vec_pend) |=> !hard_req);

  assert_vec_hold_R8: assert property (@(posedge clk) disable iff (rst)
    vec_pend |=> ($stable(hard_req) && $stable(irq_tt)));
endmodule

bind irq_level_resolver irqr_checker u_chk (
  .clk(clk), .rst(rst), .proc_lvl(proc_lvl), .int_en(int_en),
  .vec_pend(vec_pend), .sw_op(sw_op), .sw_data(sw_data),
  .softint_q(softint_q), .hard_req(hard_req), .irq_tt(irq_tt)
);

// File: tb/irq_level_resolver_tb_top.sv
module irq_level_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ext_req = '0;
  logic [3:0]  proc_lvl = '0;
  logic        int_en = 1'b0;
  logic        vec_pend = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  saved_tt = '0;
  logic [1:0]  sw_op = '0;
  logic [16:0] sw_data = '0;
  logic [16:0] softint_q;
  logic        hard_req;
  logic [8:0]  irq_tt;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [16:0] m_sw, n_sw;
  logic        m_req, n_req;
  logic [8:0]  m_tt, n_tt;

  always #2 clk = ~clk;

  irq_level_resolver dut_i (
    .clk(clk), .rst(rst), .ext_req(ext_req), .proc_lvl(proc_lvl),
    .int_en(int_en), .vec_pend(vec_pend), .trap_lvl(trap_lvl),
    .saved_tt(saved_tt), .sw_op(sw_op), .sw_data(sw_data),
    .softint_q(softint_q), .hard_req(hard_req), .irq_tt(irq_tt)
  );

  task automatic model_next();
    logic [15:0] eff;
    int win;
    n_sw = m_sw; n_req = m_req; n_tt = m_tt;
    if (rst) begin
      n_sw = '0; n_req = 0; n_tt = '0;
      return;
    end
    eff = ext_req | (m_sw[15:0] & 16'hFFFE);
    if (m_sw[0] || m_sw[16]) eff[14] = 1'b1;
    if (!vec_pend) begin
      if (int'(eff) < (2 << proc_lvl) || !int_en) begin
        n_req = 0; n_tt = '0;
      end else begin
        win = -1;
        for (int i = 15; i > int'(proc_lvl); i--)
          if (win < 0 && eff[i]) win = i;
        if (win >= 0) begin
          if (!(trap_lvl != 0 && int'(saved_tt) > 64 + win && (saved_tt >> 4) == 9'd4)
              && int'(m_tt) != 64 + win) begin
            n_req = 1; n_tt = 9'(64 + win);
          end
        end
      end
    end
    case (sw_op)
      2'd1: n_sw = m_sw | sw_data;
      2'd2: n_sw = m_sw & ~sw_data;
      2'd3: n_sw = sw_data;
      default: ;
    endcase
  endtask

  task automatic cyc(input string tag);
    model_next();
    @(posedge clk);
    m_sw = n_sw; m_req = n_req; m_tt = n_tt;
    @(negedge clk);
    total++;
    if (softint_q !== m_sw || hard_req !== m_req || irq_tt !== m_tt) begin
      bad++;
      $display("FAIL %s: got sw=%h req=%b tt=%h expected sw=%h req=%b tt=%h",
               tag, softint_q, hard_req, irq_tt, m_sw, m_req, m_tt);
    end
  endtask

  task automatic drive(input logic [15:0] e, input logic [3:0] p, input logic en,
                       input logic vp, input logic [2:0] tl, input logic [8:0] st,
                       input logic [1:0] op, input logic [16:0] d);
    ext_req = e; proc_lvl = p; int_en = en; vec_pend = vp;
    trap_lvl = tl; saved_tt = st; sw_op = op; sw_data = d;
  endtask

  task automatic expect_bit(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    m_sw = '0; m_req = 0; m_tt = '0;
    cyc("R1 reset");
    cyc("R1 reset");
    rst = 1'b0;
    // R2 software register operations
    drive(16'h0, 4'd15, 1, 0, 0, 0, 2'd3, 17'h1_2345); cyc("R2 write");
    drive(16'h0, 4'd15, 1, 0, 0, 0, 2'd1, 17'h0_00F0); cyc("R2 set");
    drive(16'h0, 4'd15, 1, 0, 0, 0, 2'd2, 17'h1_0300); cyc("R2 clear");
    drive(16'h0, 4'd15, 1, 0, 0, 0, 2'd0, 17'h1_FFFF); cyc("R2 nop");
    drive(16'h0, 4'd15, 1, 0, 0, 0, 2'd3, 17'h0);      cyc("R2 write zero");
    // R3 timer bits fold into level 14
    drive(16'h0, 4'd3, 1, 0, 0, 0, 2'd3, 17'h0_0001); cyc("R3 tick");
    drive(16'h0, 4'd3, 1, 0, 0, 0, 2'd0, 17'h0);      cyc("R3 tick eval");
    drive(16'h0, 4'd3, 1, 0, 0, 0, 2'd3, 17'h1_0000); cyc("R3 stick");
    drive(16'h0, 4'd3, 1, 0, 0, 0, 2'd0, 17'h0);      cyc("R3 stick eval");
    drive(16'h0, 4'd14, 1, 0, 0, 0, 2'd3, 17'h0);     cyc("R3 masked level");
    drive(16'h0001, 4'd0, 1, 0, 0, 0, 2'd0, 17'h0);   cyc("R4 bit0 only");
    // R4 threshold and R5 priority
    drive(16'h0100, 4'd8, 1, 0, 0, 0, 2'd0, 0); cyc("R4 at level");
    drive(16'h0100, 4'd7, 1, 0, 0, 0, 2'd0, 0); cyc("R5 just above");
    drive(16'h8102, 4'd1, 1, 0, 0, 0, 2'd0, 0); cyc("R5 highest wins");
    drive(16'h8102, 4'd1, 1, 0, 0, 0, 2'd0, 0); cyc("R5 same tt hold");
    drive(16'h0006, 4'd0, 1, 0, 0, 0, 2'd0, 0); cyc("R5 lower level");
    drive(16'h0006, 4'd2, 0, 0, 0, 0, 2'd0, 0); cyc("R4 below disabled");
    // R6 nested suppression
    drive(16'h0008, 4'd0, 1, 0, 3'd1, 9'h04A, 2'd0, 0); cyc("R6 suppressed");
    drive(16'h0800, 4'd0, 1, 0, 3'd1, 9'h04A, 2'd0, 0); cyc("R6 higher passes");
    drive(16'h0008, 4'd0, 1, 0, 3'd1, 9'h04C, 2'd0, 0); cyc("R6 hold old");
    drive(16'h0008, 4'd0, 1, 0, 3'd0, 9'h04C, 2'd0, 0); cyc("R6 tl zero");
    drive(16'h0004, 4'd0, 1, 0, 3'd2, 9'h05C, 2'd0, 0); cyc("R6 non ext type");
    // R7 disabled
    drive(16'h0004, 4'd0, 0, 0, 0, 0, 2'd0, 0); cyc("R7 disable clears");
    drive(16'h2000, 4'd0, 1, 0, 0, 0, 2'd0, 0); cyc("R7 re-enable");
    // R8 vectored pending freezes
    drive(16'h0000, 4'd0, 0, 1, 0, 0, 2'd1, 17'h00020); cyc("R8 freeze");
    drive(16'h4000, 4'd0, 1, 1, 0, 0, 2'd0, 0);         cyc("R8 freeze 2");
    expect_bit("R8 hard_req held", hard_req, 1'b1);
    drive(16'h0000, 4'd0, 1, 0, 0, 0, 2'd3, 0);         cyc("R8 release");
    drive(16'h0000, 4'd0, 1, 0, 0, 0, 2'd0, 0);         cyc("R8 release 2");
    // R9 latency of a software write
    drive(16'h0000, 4'd0, 1, 0, 0, 0, 2'd3, 17'h00020); cyc("R9 write");
    expect_bit("R9 no req after one edge", hard_req, 1'b0);
    drive(16'h0000, 4'd0, 1, 0, 0, 0, 2'd0, 0);         cyc("R9 eval");
    expect_bit("R9 req after two edges", hard_req, 1'b1);
    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] tlv;
      tlv = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      drive(16'($urandom) & 16'($urandom), 4'($urandom), ($urandom_range(0, 7) != 0),
            ($urandom_range(0, 15) == 0), tlv,
            ($urandom_range(0, 1) == 0) ? 9'(9'h040 | 9'($urandom_range(0, 15))) : 9'($urandom),
            2'($urandom), 17'($urandom) & 17'($urandom));
      cyc("R5 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule